// File: doc/BRIEF.md
# Masked Strided Vector Element Sequencer

This block steps through the elements of a single vector instruction, one element per clock cycle. On a start request it captures a base address, a signed stride, an element count and an operation kind. For every element slot it then presents an element index and a memory address. In apply mode it also raises an enable that the per-element mask bit gates. That enable feeds a pipelined element functional unit. Elements follow one another back to back, with no hazard checks between them. A slot whose mask bit is clear is still spent, but the unit must leave that destination element unchanged.

In test mode the block writes its own mask register instead of enabling the unit. It compares each supplied element value with zero and stores the result in the mask bit for that element. The element values arrive on a data input, which the surrounding datapath drives from the current index in the same cycle. Both modes finish with a one-cycle done pulse. The pulse comes once the last element has had time to leave the final stage of the functional unit pipeline.

Top module: `vseq_engine`

## Requirements
- R1: After reset, busy, iss_valid, iss_en and done are 0 and all bits of mask_out are 1.
- R2: A start sampled while idle with effective length L > 0 produces L consecutive cycles with iss_valid = 1. The first of these is the cycle after the sampling edge. iss_idx is 0, 1, …, L−1 in those cycles.
- R3: In the slot for element i, iss_addr equals base_addr + i × stride modulo 2^ADDR_W. The stride is taken as two's complement, so negative strides walk downward and wrap.
- R4: A requested length above NUM_ELEM is treated as exactly NUM_ELEM elements.
- R5: With op_test = 0 (apply), iss_en in the slot for element i equals mask bit i. A slot with a clear mask bit still has iss_valid = 1.
- R6: With op_test = 1 (test), each slot i < L writes mask bit i to 1 if tst_data is all zeros and to 0 otherwise. iss_en stays 0, and mask bits at positions L and above keep their values.
- R7: done is high for exactly one cycle, PIPE_STAGES cycles after the cycle of the last issued element. busy is 0 in the cycle that follows.
- R8: A start with effective length 0 issues no slot and raises done in the cycle after the sampling edge, with busy remaining 0.
- R9: A start raised while busy is ignored. The running sequence, its addresses and the mask register are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence when idle |
| op_test | input | 1 | 0 = apply to functional unit, 1 = compare-with-zero into mask |
| base_addr | input | ADDR_W | Address of element 0 |
| stride | input | ADDR_W | Two's-complement address step between elements |
| vlen | input | LEN_W | Requested element count |
| tst_data | input | ELEM_W | Element value for the current index in test mode |
| busy | output | 1 | A sequence or its drain is in progress |
| iss_valid | output | 1 | An element slot is occupied this cycle |
| iss_en | output | 1 | Functional unit enable for this slot (mask-gated) |
| iss_idx | output | IDX_W | Index of the element in this slot |
| iss_addr | output | ADDR_W | Memory address of the element in this slot |
| done | output | 1 | One-cycle completion pulse |
| mask_out | output | NUM_ELEM | Current mask register |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a running or draining sequence, which must change nothing. The stimulus injects such a pulse partway through a short apply run, with different parameters and the test operation selected. It then checks that every later slot, the done timing and the mask all match a run that saw no interruption. Partial-length test runs, and mask patterns built by earlier test runs, also take deliberate sequencing. These runs show that bits above the length survive and that apply slots follow the mask bit by bit.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } vseq_state_e;

  typedef enum logic {
    OP_APPLY = 1'b0,
    OP_TEST  = 1'b1
  } vseq_op_e;

endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int NUM_ELEM = 64,
  parameter int IDX_W    = 6,
  parameter int LEN_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_in,
  input  logic [LEN_W-1:0] vlen,
  input  logic             tail_done,
  output logic             accept,
  output logic             run_valid,
  output logic             run_last,
  output logic [IDX_W-1:0] run_idx,
  output vseq_op_e         op_q,
  output logic             zero_done,
  output logic             busy
);

  vseq_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] len_eff;
  vseq_op_e         op_d;
  logic             zero_q, zero_d;

  assign len_eff   = (vlen > LEN_W'(NUM_ELEM)) ? LEN_W'(NUM_ELEM) : vlen;
  assign accept    = start && (state_q == ST_IDLE);
  assign run_valid = (state_q == ST_ISSUE);
  assign run_last  = run_valid && ((LEN_W'(idx_q) + LEN_W'(1)) == len_q);
  assign run_idx   = idx_q;
  assign zero_done = zero_q;
  assign busy      = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    len_d   = len_q;
    op_d    = op_q;
    zero_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          len_d = len_eff;
          op_d  = vseq_op_e'(op_in);
          idx_d = '0;
          if (len_eff == '0) begin
            zero_d = 1'b1;
          end else begin
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        idx_d = idx_q + IDX_W'(1);
        if (run_last) begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (tail_done) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      op_q    <= OP_APPLY;
      zero_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      op_q    <= op_d;
      zero_q  <= zero_d;
    end
  end

endmodule

// File: rtl/vseq_addr_gen.sv
module vseq_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] stride_q
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] stride_d;

  always_comb begin
    addr_d   = addr_q;
    stride_d = stride_q;
    if (load) begin
      addr_d   = base;
      stride_d = stride;
    end else if (step) begin
      addr_d = addr_q + stride_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
    end else begin
      addr_q   <= addr_d;
      stride_q <= stride_d;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/vseq_mask_bank.sv
module vseq_mask_bank #(
  parameter int NUM_ELEM = 64,
  parameter int ELEM_W   = 64,
  parameter int IDX_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [ELEM_W-1:0]   wr_data,
  output logic [NUM_ELEM-1:0] mask
);

  logic is_zero;
  assign is_zero = (wr_data == '0);

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_bit
    logic bit_q, bit_d, bit_we;
    assign bit_we = wr && (wr_idx == IDX_W'(g));

    always_comb begin
      bit_d = bit_q;
      if (bit_we) begin
        bit_d = is_zero;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b1;
      end else begin
        bit_q <= bit_d;
      end
    end

    assign mask[g] = bit_q;
  end

endmodule

// File: rtl/vseq_tail_pipe.sv
module vseq_tail_pipe #(
  parameter int STAGES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic last_in,
  output logic tail_out
);

  logic [STAGES-1:0] sr_q, sr_d;

  if (STAGES == 1) begin : g_one
    assign sr_d = last_in;
  end else begin : g_many
    assign sr_d = {sr_q[STAGES-2:0], last_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign tail_out = sr_q[STAGES-1];

endmodule

// File: rtl/vseq_engine.sv
module vseq_engine
  import vseq_pkg::*;
#(
  parameter int NUM_ELEM    = 64,
  parameter int ELEM_W      = 64,
  parameter int ADDR_W      = 32,
  parameter int PIPE_STAGES = 6,
  localparam int IDX_W      = $clog2(NUM_ELEM),
  localparam int LEN_W      = $clog2(NUM_ELEM + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                op_test,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [ADDR_W-1:0]   stride,
  input  logic [LEN_W-1:0]    vlen,
  input  logic [ELEM_W-1:0]   tst_data,
  output logic                busy,
  output logic                iss_valid,
  output logic                iss_en,
  output logic [IDX_W-1:0]    iss_idx,
  output logic [ADDR_W-1:0]   iss_addr,
  output logic                done,
  output logic [NUM_ELEM-1:0] mask_out
);

  logic             accept, run_valid, run_last, zero_done, tail_done;
  logic [IDX_W-1:0] run_idx;
  vseq_op_e         op_q;
  logic [ADDR_W-1:0] stride_q;
  logic             test_wr;

  vseq_ctrl #(
    .NUM_ELEM (NUM_ELEM),
    .IDX_W    (IDX_W),
    .LEN_W    (LEN_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_in     (op_test),
    .vlen      (vlen),
    .tail_done (tail_done),
    .accept    (accept),
    .run_valid (run_valid),
    .run_last  (run_last),
    .run_idx   (run_idx),
    .op_q      (op_q),
    .zero_done (zero_done),
    .busy      (busy)
  );

  vseq_addr_gen #(
    .ADDR_W (ADDR_W)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (run_valid),
    .base     (base_addr),
    .stride   (stride),
    .addr     (iss_addr),
    .stride_q (stride_q)
  );

  assign test_wr = run_valid && (op_q == OP_TEST);

  vseq_mask_bank #(
    .NUM_ELEM (NUM_ELEM),
    .ELEM_W   (ELEM_W),
    .IDX_W    (IDX_W)
  ) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (test_wr),
    .wr_idx  (run_idx),
    .wr_data (tst_data),
    .mask    (mask_out)
  );

  vseq_tail_pipe #(
    .STAGES (PIPE_STAGES)
  ) u_tail (
    .clk      (clk),
    .rst_n    (rst_n),
    .last_in  (run_last),
    .tail_out (tail_done)
  );

  assign iss_valid = run_valid;
  assign iss_idx   = run_idx;
  assign iss_en    = run_valid && (op_q == OP_APPLY) && mask_out[run_idx];
  assign done      = tail_done || zero_done;

endmodule

// File: rtl/vseq_engine_chk.sv
module vseq_engine_chk
  import vseq_pkg::*;
#(
  parameter int NUM_ELEM = 64,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_en,
  input logic [IDX_W-1:0]  iss_idx,
  input logic [ADDR_W-1:0] iss_addr,
  input logic              done,
  input logic              busy,
  input logic [ADDR_W-1:0] stride_q,
  input vseq_op_e          op_q
);

  // R2: consecutive slots carry consecutive indices
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid)) |-> (iss_idx == $past(iss_idx) + IDX_W'(1)));

  // R3: consecutive slots are one stride apart
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid)) |-> (iss_addr == $past(iss_addr) + stride_q));

  // R5: an enable only appears in an occupied slot
  p_en_in_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_en |-> iss_valid);

  // R6: test operation never enables the functional unit
  p_test_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (op_q == OP_TEST)) |-> !iss_en);

  // R7: completion never coincides with an issued element
  p_done_after_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !iss_valid);

  // R9: the operation kind holds for a whole run
  p_op_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid)) |-> $stable(op_q));

  // R2: slots only occur while busy
  p_slot_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> busy);

endmodule

bind vseq_engine vseq_engine_chk #(
  .NUM_ELEM (NUM_ELEM),
  .ADDR_W   (ADDR_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_en    (iss_en),
  .iss_idx   (iss_idx),
  .iss_addr  (iss_addr),
  .done      (done),
  .busy      (busy),
  .stride_q  (stride_q),
  .op_q      (op_q)
);

// File: tb/sim_vseq_engine.sv
module sim_vseq_engine;

  localparam int N     = 64;
  localparam int EW    = 64;
  localparam int AW    = 32;
  localparam int PS    = 6;
  localparam int IW    = $clog2(N);
  localparam int LW    = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          op_test;
  logic [AW-1:0] base_addr;
  logic [AW-1:0] stride;
  logic [LW-1:0] vlen;
  logic [EW-1:0] tst_data;
  logic          busy, iss_valid, iss_en, done;
  logic [IW-1:0] iss_idx;
  logic [AW-1:0] iss_addr;
  logic [N-1:0]  mask_out;

  logic [EW-1:0] vec_mem [N];
  logic [N-1:0]  mask_m;
  int            n_checks = 0;
  int            n_errors = 0;

  always #2 clk = ~clk;

  assign tst_data = vec_mem[iss_idx];

  vseq_engine u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_test   (op_test),
    .base_addr (base_addr),
    .stride    (stride),
    .vlen      (vlen),
    .tst_data  (tst_data),
    .busy      (busy),
    .iss_valid (iss_valid),
    .iss_en    (iss_en),
    .iss_idx   (iss_idx),
    .iss_addr  (iss_addr),
    .done      (done),
    .mask_out  (mask_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int req);
    return (req > N) ? N : req;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input logic [AW-1:0] s, input int k);
    return b + s * AW'(k);
  endfunction

  // one full sequence; poke_at >= 0 raises a stray start in that slot (R9)
  task automatic run_seq(input bit op, input logic [AW-1:0] b, input logic [AW-1:0] s,
                         input int req, input int poke_at);
    int le;
    le = eff_len(req);
    @(negedge clk);
    start = 1'b1; op_test = op; base_addr = b; stride = s; vlen = LW'(req);
    if (le == 0) begin
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R8 done after zero length", 64'(done), 64'd1);
      chk(iss_valid == 1'b0, "R8 no slot for zero length", 64'(iss_valid), 64'd0);
      chk(busy == 1'b0, "R8 stays idle", 64'(busy), 64'd0);
      @(negedge clk);
      chk(done == 1'b0, "R7 done single cycle", 64'(done), 64'd0);
      return;
    end
    for (int k = 0; k < le + PS; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      chk(iss_valid == (k < le), "R2 slot occupancy", 64'(iss_valid), 64'(k < le));
      chk(done == (k == le + PS - 1), "R7 done timing", 64'(done), 64'(k == le + PS - 1));
      if (k < le) begin
        chk(iss_idx == IW'(k), "R2 element index", 64'(iss_idx), 64'(k));
        chk(iss_addr == exp_addr(b, s, k), "R3 element address", 64'(iss_addr), 64'(exp_addr(b, s, k)));
        if (op) begin
          chk(iss_en == 1'b0, "R6 no enable in test", 64'(iss_en), 64'd0);
          mask_m[k] = (vec_mem[k] == '0);
        end else begin
          chk(iss_en == mask_m[k], "R5 mask gated enable", 64'(iss_en), 64'(mask_m[k]));
        end
      end
      if (k == poke_at) begin
        start = 1'b1; op_test = 1'b1; vlen = LW'(3); base_addr = 32'hDEAD_0000; stride = 32'd4;
      end else if (poke_at >= 0 && k == poke_at + 1) begin
        start = 1'b0;
      end
    end
    @(negedge clk);
    chk(busy == 1'b0, "R7 idle after done", 64'(busy), 64'd0);
    chk(done == 1'b0, "R7 done single cycle", 64'(done), 64'd0);
    chk(mask_out == mask_m, "R6 mask contents", mask_out, mask_m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4471));
    for (int i = 0; i < N; i++) vec_mem[i] = 64'd1;
    rst_n = 1'b0; start = 1'b0; op_test = 1'b0;
    base_addr = '0; stride = '0; vlen = '0;
    mask_m = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
    chk(iss_valid == 1'b0, "R1 valid", 64'(iss_valid), 64'd0);
    chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
    chk(mask_out == '1, "R1 mask all ones", mask_out, '1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(iss_en == 1'b0, "R1 enable", 64'(iss_en), 64'd0);

    // R2 R3 R5: short apply run with full mask
    run_seq(1'b0, 32'h0000_1000, 32'd8, 8, -1);
    // R8: zero length
    run_seq(1'b0, 32'h0000_2000, 32'd8, 0, -1);
    // R6: full-length test with every third element zero
    for (int i = 0; i < N; i++) vec_mem[i] = (i % 3 == 0) ? 64'd0 : 64'(i) << 40;
    run_seq(1'b1, 32'h0, 32'd0, N, -1);
    // R5 R3: apply under that mask, negative stride wrapping below zero
    run_seq(1'b0, 32'h0000_0010, 32'hFFFF_FFF8, N, -1);
    // R6: partial test leaves upper bits alone
    for (int i = 0; i < N; i++) vec_mem[i] = (i % 2 == 0) ? 64'd0 : 64'h8000_0000_0000_0000;
    run_seq(1'b1, 32'h0, 32'd0, 10, -1);
    // R4: requested length above capacity
    run_seq(1'b0, 32'hFFFF_FF00, 32'd16, 100, -1);
    // R9: stray start in mid run is ignored
    run_seq(1'b0, 32'h0000_4000, 32'd12, 5, 2);
    // R9: stray start during drain is ignored
    run_seq(1'b0, 32'h0000_5000, 32'd4, 3, 4);

    // random mix
    for (int r = 0; r < 16; r++) begin
      for (int i = 0; i < N; i++)
        vec_mem[i] = ($urandom_range(0, 2) == 0) ? 64'd0 : {$urandom(), $urandom()} | 64'd1;
      run_seq(1'($urandom_range(0, 1)), $urandom(), $urandom(), int'($urandom_range(0, 80)), -1);
    end

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule